// File: doc/BRIEF.md
# MSB-first asynchronous serial character link

This block carries 8-bit character codes over one wire with no shared clock. The transmit half takes a byte with a one-cycle strobe. It drives a frame onto its output line: a low start bit, the eight data bits, then a high stop bit. Unlike the usual convention, the data bits go out with the most significant bit first. Every bit lasts a fixed number of system clock cycles, and that number is a parameter shared by both ends.

The receive half passes its line input through a synchronizer and waits for a falling edge. At half a bit period it checks the line again, so that short glitches are thrown away. It then reads each data bit once at the centre of its bit time, with the first bit received landing in the MSB. It checks the stop bit and reports either a good byte or a framing error. The two halves are independent: the bench may loop the transmit line back into the receive line, or drive the receive line directly.

Top module: `serlink_msb`

## Requirements
- R1: After reset, tx_line is high, tx_busy is low, rx_valid and rx_frame_err are low, and rx_data is zero.
- R2: A frame is ten bit times of CLKS_PER_BIT cycles each: one low bit, the data byte from bit 7 down to bit 0, and one high bit. For example, 0x41 appears on the line as 0,0,1,0,0,0,0,0,1,1.
- R3: A tx_valid seen at a clock edge while tx_busy is low is accepted. tx_line goes low in the cycle after that edge.
- R4: tx_busy is high for exactly 10*CLKS_PER_BIT cycles from acceptance, and tx_line is high whenever tx_busy is low.
- R5: tx_valid has no effect while tx_busy is high, including in the last cycle of the stop bit. A strobe held into the following cycle is accepted.
- R6: A received frame with a high stop bit gives a single-cycle rx_valid with the byte in rx_data, first bit received in bit 7. The pulse appears 3 + CLKS_PER_BIT/2 + 9*CLKS_PER_BIT cycles after the edge at which the line fell.
- R7: A low pulse on the receive line that is over before half a bit period produces neither rx_valid nor rx_frame_err.
- R8: A frame whose stop bit is sampled low gives a single-cycle rx_frame_err, at the same time rx_valid would have come, and no rx_valid.
- R9: After a framing error, the receiver looks for a new start bit only once the line has been high again.
- R10: rx_data changes only together with rx_valid, so a framing error leaves the last good byte in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Send strobe |
| tx_busy | output | 1 | Frame in progress on tx_line |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last byte received correctly |
| rx_valid | output | 1 | One-cycle pulse for a good byte |
| rx_frame_err | output | 1 | One-cycle pulse for a low stop bit |

## Verification
Two things can land on the same clock edge: the transmitter finishing its stop bit and a new send strobe. The bench raises tx_valid exactly in the final stop-bit cycle and holds it one more cycle. A reference model must then see the first edge ignored and the second accepted, with the line compared every clock. On the receive side, a framing error followed by a line that stays low puts the end-of-frame decision and the start-edge search against each other. The bench expects one error pulse and no phantom frame before the line returns high.

// File: rtl/serlink_pkg.sv
// Shared state encodings for the serial character link.
package serlink_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_RECOVER} rx_state_t;
endpackage

// File: rtl/serlink_sync.sv
// Multi-stage synchronizer for the asynchronous receive line.
// Assumes STAGES >= 2; resets to the idle (high) level.
module serlink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/serlink_tx.sv
// Frame transmitter: start bit low, data MSB first, stop bit high.
// Assumes CLKS_PER_BIT >= 2. Strobes are ignored while a frame runs.
module serlink_tx
    import serlink_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 valid,
    output logic                 busy,
    output logic                 line
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

    tx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] sh;

    // Frame sequencer: bit timer, shift register and registered line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            line  <= 1'b1;
        end else if (state == TX_IDLE) begin
            if (valid) begin
                sh    <= data;
                cnt   <= '0;
                line  <= 1'b0;
                state <= TX_START;
            end
        end else if (cnt != CNT_LAST) begin
            cnt <= cnt + CW'(1);
        end else begin
            cnt <= '0;
            case (state)
                TX_START: begin
                    state <= TX_DATA;
                    idx   <= '0;
                    line  <= sh[DATA_BITS-1];
                end
                TX_DATA: begin
                    if (idx == IDX_LAST) begin
                        state <= TX_STOP;
                        line  <= 1'b1;
                    end else begin
                        idx  <= idx + IW'(1);
                        sh   <= sh << 1;
                        line <= sh[DATA_BITS-2];
                    end
                end
                default: begin
                    state <= TX_IDLE;
                    line  <= 1'b1;
                end
            endcase
        end
    end

    assign busy = (state != TX_IDLE);

    // R4: line rests high outside a frame
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    // R3: an accepted strobe starts the frame with a low bit
    a_r3_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && valid) |=> (busy && !line));
    // R5: strobe during a frame does not reload the shifter mid-start
    a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && valid) |=> $stable(sh));
endmodule

// File: rtl/serlink_rx.sv
// Frame receiver: confirms the start bit at half a bit, samples each
// data bit at mid-bit into the MSB end first, checks the stop bit.
// Assumes a synchronized line input and CLKS_PER_BIT >= 4.
module serlink_rx
    import serlink_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_in,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 frame_err
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    rx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] sh;

    // Receive sequencer: edge hunt, glitch check, sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            sh        <= '0;
            data      <= '0;
            valid     <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            valid     <= 1'b0;
            frame_err <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!bit_in) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= bit_in ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        sh  <= {sh[DATA_BITS-2:0], bit_in};
                        if (idx == IDX_LAST) state <= RX_STOP;
                        else                 idx <= idx + IW'(1);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        if (bit_in) begin
                            valid <= 1'b1;
                            data  <= sh;
                            state <= RX_IDLE;
                        end else begin
                            frame_err <= 1'b1;
                            state     <= RX_RECOVER;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    if (bit_in) state <= RX_IDLE;
                end
            endcase
        end
    end

    // R8: a frame ends either good or bad, never both
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && frame_err));
    // R6: data valid is a single-cycle pulse
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R10: output byte holds between good frames
    a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(data));
    // R9: after an error the receiver does not start a frame on a low line
    a_r9_recover: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (state == RX_RECOVER));
endmodule

// File: rtl/serlink_msb.sv
// Top of the MSB-first serial link: independent transmit and receive
// halves sharing one bit-period parameter.
module serlink_msb #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_busy,
    output logic                 tx_line,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    logic rx_bit;

    serlink_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .data(tx_data), .valid(tx_valid),
        .busy(tx_busy), .line(tx_line)
    );

    serlink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_bit)
    );

    serlink_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .data(rx_data),
        .valid(rx_valid), .frame_err(rx_frame_err)
    );
endmodule

// File: tb/tb_serlink_msb.sv
// Bench: behavioural reference model updated at each rising edge and
// compared with every output at each falling edge.
module tb_serlink_msb;
    localparam int C     = 16;
    localparam int FRAME = 10 * C;
    localparam int RXLAT = 3 + C / 2 + 9 * C;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_busy, tx_line;
    logic       rx_line;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err;
    logic       loop, drv_line;

    always #4 clk = ~clk;   // 125 MHz

    assign rx_line = loop ? tx_line : drv_line;

    serlink_msb #(.CLKS_PER_BIT(C)) dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_busy(tx_busy), .tx_line(tx_line), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    int         cyc = 0;
    bit         m_busy = 0;
    int         m_t = 0;
    logic [7:0] m_byte = '0;
    bit         e_v = 0, e_e = 0;
    logic [7:0] e_d = '0;
    logic [7:0] last_good = '0;
    int         q_cyc[$];
    logic [7:0] q_dat[$];
    bit         q_err[$];

    function automatic logic frame_bit(logic [7:0] b, int i);
        if (i == 0) return 1'b0;
        if (i == 9) return 1'b1;
        return b[8 - i];   // MSB first
    endfunction

    // Reference model: advances one clock per rising edge.
    always @(posedge clk) begin
        cyc++;
        e_v = 0;
        e_e = 0;
        if (!rst_n) begin
            m_busy = 0;
            m_t = 0;
            last_good = '0;
            q_cyc.delete(); q_dat.delete(); q_err.delete();
        end else begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                e_v = !q_err[0];
                e_e = q_err[0];
                e_d = q_dat[0];
                if (e_v) last_good = e_d;
                void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_err.pop_front());
            end
            if (m_busy) begin
                m_t++;
                if (m_t == FRAME) m_busy = 0;
            end else if (tx_valid) begin
                m_busy = 1;
                m_t = 0;
                m_byte = tx_data;
                if (loop) begin
                    q_cyc.push_back(cyc + RXLAT);
                    q_dat.push_back(tx_data);
                    q_err.push_back(1'b0);
                end
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cyc >= 1) begin
            logic exp_line;
            exp_line = m_busy ? frame_bit(m_byte, m_t / C) : 1'b1;
            chk(tx_line === exp_line, "R2", "tx_line", int'(tx_line), int'(exp_line));
            chk(tx_busy === m_busy, "R4", "tx_busy", int'(tx_busy), int'(m_busy));
            chk(rx_valid === e_v, "R6", "rx_valid", int'(rx_valid), int'(e_v));
            chk(rx_frame_err === e_e, "R8", "rx_frame_err", int'(rx_frame_err), int'(e_e));
            chk(rx_data === last_good, "R10", "rx_data", int'(rx_data), int'(last_good));
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk);
        while (m_busy) @(negedge clk);
        tx_data = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        // R3: accepted, line low in the cycle after the edge
        chk(tx_line === 1'b0, "R3", "start bit", int'(tx_line), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy || q_cyc.size() > 0) @(negedge clk);
        repeat (C) @(negedge clk);
    endtask

    // Drive one frame directly on the receive line; stop_hi selects stop bit.
    task automatic drive_frame(logic [7:0] b, bit stop_hi, int tail_low);
        @(negedge clk);
        q_cyc.push_back(cyc + RXLAT);
        q_dat.push_back(b);
        q_err.push_back(!stop_hi);
        for (int i = 0; i < 10; i++) begin
            drv_line = (i == 9) ? stop_hi : frame_bit(b, i);
            repeat (C) @(negedge clk);
        end
        repeat (tail_low) @(negedge clk);
        drv_line = 1'b1;
        repeat (2 * C) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; loop = 1'b1; drv_line = 1'b1;
        tx_valid = 1'b0; tx_data = '0;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(tx_line === 1'b1 && tx_busy === 1'b0, "R1", "tx idle", int'({tx_busy, tx_line}), 1);
        chk(rx_valid === 1'b0 && rx_frame_err === 1'b0 && rx_data === 8'h00, "R1", "rx idle",
            int'({rx_valid, rx_frame_err, rx_data}), 0);
        rst_n = 1'b1;

        // R2, R6: loopback of several patterns, 0x41 first
        send(8'h41);
        send(8'hA5);
        send(8'h00);
        send(8'hFF);
        send(8'h5A);
        wait_idle();
        chk(rx_data === 8'h5A, "R6", "last byte", int'(rx_data), 8'h5A);

        // R5: strobe mid-frame is ignored
        send(8'h3C);
        repeat (40) @(negedge clk);
        tx_data = 8'h99; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        // R5: strobe in the final stop cycle, held one more cycle
        while (!(m_busy && m_t == FRAME - 1)) @(negedge clk);
        tx_data = 8'hC3; tx_valid = 1'b1;
        @(negedge clk);
        chk(tx_busy === 1'b0, "R5", "busy after stop", int'(tx_busy), 0);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_busy === 1'b1 && tx_line === 1'b0, "R5", "held strobe accepted",
            int'({tx_busy, tx_line}), 2);
        wait_idle();
        chk(rx_data === 8'hC3, "R5", "second byte received", int'(rx_data), 8'hC3);

        // direct drive of the receive line
        loop = 1'b0;
        // R7: glitch shorter than half a bit
        @(negedge clk);
        drv_line = 1'b0;
        repeat (3) @(negedge clk);
        drv_line = 1'b1;
        repeat (3 * C) @(negedge clk);
        chk(rx_data === 8'hC3, "R7", "glitch ignored", int'(rx_data), 8'hC3);
        // R6: directly driven good frame
        drive_frame(8'h81, 1'b1, 0);
        // R8, R9: low stop bit then line held low for two bit times
        drive_frame(8'h6E, 1'b0, 2 * C);
        chk(rx_data === 8'h81, "R10", "data kept after error", int'(rx_data), 8'h81);
        // R9: receiver resumes after line returned high
        drive_frame(8'h17, 1'b1, 0);
        wait_idle();
        chk(rx_data === 8'h17, "R9", "frame after recovery", int'(rx_data), 8'h17);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule